// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter

This block turns bytes into an asynchronous serial stream. A byte written into a 16-entry queue is sent as one frame of ten bits. The frame is a low start bit, then eight data bits with the least significant bit first, then a high stop bit. Each bit lasts sixteen pulses of an external bit-rate enable, so the clock rate and the line rate can be chosen separately. When no frame is being sent, the line rests high.

The far end can pause the stream with an active-low clear-to-send input. That pin first passes through a two-stage synchroniser. The synchronised value is consulted only at the moment a new byte would be taken from the queue. As a result, a frame that has already started always completes. A byte that is still waiting stays queued, with the line held high, until clear-to-send is asserted again.

A write to a full queue is discarded and raises a sticky overflow flag that only reset clears. A status output reports when the queue is empty and the last stop bit has fully left the line.

Top module: `uart_cts_tx`

## Requirements
- R1: Every frame on `tx_line` is one low start bit, then data bits 0 through 7 in that order (bit 0 first), then one high stop bit. Outside a frame the line is high.
- R2: Each bit of a frame, the start and stop bits included, lasts 16 cycles in which `bit_tick` is high, for any spacing of those ticks.
- R3: Bytes leave in the order they were written. The queue holds up to 16 bytes while the line is stalled.
- R4: A write while 16 bytes are queued is discarded and sets `tx_overflow` one cycle later. The flag then stays high until reset, and the 16 queued bytes are still sent unchanged.
- R5: Raising `cts_n_pin` (deasserting it) while a frame is on the line does not shorten or alter that frame.
- R6: While the synchronised clear-to-send is deasserted, no new start bit is issued and `tx_line` stays high, even with bytes queued.
- R7: Once clear-to-send is asserted again, the next frame sent carries the oldest queued byte.
- R8: A byte written while clear-to-send is deasserted, with the transmitter idle, is not sent until clear-to-send is asserted.
- R9: `tx_empty` is high only when the queue is empty and no frame is in progress. It drops at the first clock edge after an accepted write and rises at the end of the last stop bit.
- R10: While reset is high and just after it, `tx_line` is 1, `tx_empty` is 1 and `tx_overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | Bit-rate enable, one-cycle pulses |
| wr_en | input | 1 | Write strobe into the transmit queue |
| wr_data | input | 8 | Byte to queue |
| cts_n_pin | input | 1 | Asynchronous clear-to-send, low means send allowed |
| tx_line | output | 1 | Serial output, idles high |
| tx_empty | output | 1 | Queue empty and no frame in progress |
| tx_overflow | output | 1 | Sticky flag for a write dropped on a full queue |

## Verification
The queue status responds one edge after a write: `tx_empty` is sampled low at the falling edge that follows the accepting rising edge, and `tx_overflow` is sampled at the falling edge right after the seventeenth write. The line has no fixed latency. The start bit begins between one and P clock cycles before the first counted tick, where P is the tick spacing. For this reason the bench receiver locks onto the falling start edge and then samples each bit 8·P cycles into it, and every 16·P cycles after that. This keeps each sample at least P cycles away from a bit boundary. Changes to clear-to-send take effect only after the two synchroniser stages and at the next frame boundary. The checks for stall and resumption therefore look at whole frames and long quiet windows rather than at single cycles.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = BYTE_W + 2;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    // Bit 0 of the packed frame goes out first.
    typedef struct packed {
        logic              stop_bit;
        logic [BYTE_W-1:0] payload;
        logic              start_bit;
    } tx_frame_t;

    function automatic tx_frame_t build_frame(input logic [BYTE_W-1:0] b);
        tx_frame_t f;
        f.start_bit = 1'b0;
        f.payload   = b;
        f.stop_bit  = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Reset to 1: the pin counts as deasserted until it has been sampled.
    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= 1'b1;
            else     chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          pop,
    output logic [W-1:0]  rd_data,
    output logic          empty,
    output logic [CW-1:0] count,
    output logic          overflow
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = wr_en && !full;
    assign pop_ok  = pop && !empty;
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr_en && full) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1,
    localparam int BW = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              have_data,
    input  logic              cts_ok,
    input  logic [BYTE_W-1:0] load_data,
    output logic              pop,
    output logic              busy,
    output logic              line
);
    tx_state_e             state;
    logic [FRAME_BITS-1:0] shreg;
    logic [TW-1:0]         tick_cnt;
    logic [BW-1:0]         bit_idx;
    logic                  bit_end;

    // Flow control is only looked at here, when a new frame would start.
    assign pop     = (state == TX_IDLE) && have_data && cts_ok;
    assign busy    = (state == TX_SEND);
    assign bit_end = bit_tick && (tick_cnt == TW'(TICKS_PER_BIT - 1));
    assign line    = busy ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_IDLE;
            shreg    <= '1;
            tick_cnt <= '0;
            bit_idx  <= '0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (pop) begin
                        shreg    <= build_frame(load_data);
                        tick_cnt <= '0;
                        bit_idx  <= '0;
                        state    <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (bit_end) begin
                        tick_cnt <= '0;
                        if (bit_idx == BW'(FRAME_BITS - 1)) begin
                            state <= TX_IDLE;
                        end else begin
                            shreg   <= {1'b1, shreg[FRAME_BITS-1:1]};
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else if (bit_tick) begin
                        tick_cnt <= tick_cnt + 1'b1;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
    import uart_tx_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int TICKS_PER_BIT = 16,
    parameter int SYNC_STAGES   = 2,
    localparam int CW           = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              cts_n_pin,
    output logic              tx_line,
    output logic              tx_empty,
    output logic              tx_overflow
);
    logic              cts_n_sync;
    logic              fifo_empty;
    logic [CW-1:0]     fifo_count;
    logic [BYTE_W-1:0] head_data;
    logic              pop;
    logic              busy;

    uart_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (cts_n_pin),
        .sync_out (cts_n_sync)
    );

    uart_tx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .pop      (pop),
        .rd_data  (head_data),
        .empty    (fifo_empty),
        .count    (fifo_count),
        .overflow (tx_overflow)
    );

    uart_tx_serializer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .have_data (!fifo_empty),
        .cts_ok    (!cts_n_sync),
        .load_data (head_data),
        .pop       (pop),
        .busy      (busy),
        .line      (tx_line)
    );

    assign tx_empty = fifo_empty && !busy;
endmodule

// File: rtl/uart_cts_tx_chk.sv
module uart_cts_tx_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          tx_line,
    input logic          tx_empty,
    input logic          tx_overflow,
    input logic          wr_en,
    input logic          cts_n_sync,
    input logic          busy,
    input logic          pop,
    input logic [CW-1:0] fifo_count
);
    AST_START_NEEDS_CTS: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(cts_n_sync)); // R8

    AST_STALL_NO_START: assert property (@(posedge clk) disable iff (rst)
        (!busy && cts_n_sync) |=> !busy); // R6

    AST_LOAD_POPS: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(pop)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH)); // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        tx_overflow |=> tx_overflow); // R4

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (fifo_count == CW'(DEPTH) && wr_en && !pop)
        |=> (fifo_count == CW'(DEPTH)) && tx_overflow); // R4

    AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> tx_line); // R9
endmodule

bind uart_cts_tx uart_cts_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_line     (tx_line),
    .tx_empty    (tx_empty),
    .tx_overflow (tx_overflow),
    .wr_en       (wr_en),
    .cts_n_sync  (cts_n_sync),
    .busy        (busy),
    .pop         (pop),
    .fifo_count  (fifo_count)
);

// File: tb/uart_cts_tx_tb.sv
`timescale 1ns/1ps
module uart_cts_tx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cts_n = 1'b0;
    logic       tx_line, tx_empty, tx_overflow;

    int errors = 0;
    int checks = 0;
    int P = 1;
    int tick_c = 0;
    int starts = 0;
    logic [7:0] rx_b;
    logic [7:0] exp_q[$];
    logic [7:0] rx_q[$];

    uart_cts_tx u_dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_data(wr_data), .cts_n_pin(cts_n), .tx_line(tx_line),
        .tx_empty(tx_empty), .tx_overflow(tx_overflow)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // bit-rate enable every P clocks
    initial begin
        forever begin
            @(negedge clk);
            tick_c++;
            if (tick_c >= P) begin tick_c = 0; bit_tick = 1'b1; end
            else bit_tick = 1'b0;
        end
    end

    // line receiver: R1 framing, R2 bit length via mid-bit sampling
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && tx_line === 1'b0) begin
                starts++;
                repeat (8*P) @(negedge clk);
                check(tx_line == 1'b0, "R1", "start bit mid level", int'(tx_line), 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (16*P) @(negedge clk);
                    rx_b[i] = tx_line;
                end
                repeat (16*P) @(negedge clk);
                check(tx_line == 1'b1, "R2", "stop bit mid level", int'(tx_line), 1);
                rx_q.push_back(rx_b);
            end
        end
    end

    task automatic push(input logic [7:0] b, input bit model);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
        if (model) exp_q.push_back(b);
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (!tx_empty && n < 40000) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
    endtask

    task automatic compare(input string req);
        check(rx_q.size() == exp_q.size(), req, "byte count", rx_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
            check(rx_q[i] == exp_q[i], req, "byte value", int'(rx_q[i]), int'(exp_q[i]));
        rx_q.delete();
        exp_q.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(tx_line == 1'b1, "R10", "line in reset", int'(tx_line), 1);
        check(tx_empty == 1'b1, "R10", "empty in reset", int'(tx_empty), 1);
        check(tx_overflow == 1'b0, "R10", "overflow in reset", int'(tx_overflow), 0);
        rst = 1'b0;
        @(negedge clk);
        check(tx_empty == 1'b1, "R9", "empty after reset", int'(tx_empty), 1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R3 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int s0;
        int n;
        void'($urandom(32'd20240611));
        do_reset();

        // R1/R2/R9: single byte, tick every clock
        P = 1;
        push(8'hA5, 1'b1);
        check(tx_empty == 1'b0, "R9", "empty drops after write", int'(tx_empty), 0);
        wait_idle();
        compare("R1");
        check(tx_empty == 1'b1, "R9", "empty after stop", int'(tx_empty), 1);

        // R1/R2: bit order corners with sparse ticks
        P = 3;
        push(8'h01, 1'b1);
        push(8'h80, 1'b1);
        wait_idle();
        compare("R2");

        // R8/R6: first byte waits for clear-to-send
        P = 1;
        cts_n = 1'b1;
        repeat (4) @(negedge clk);
        s0 = starts;
        push(8'h3C, 1'b1);
        repeat (300) @(negedge clk);
        check(starts == s0, "R8", "no start while deasserted", starts, s0);
        check(tx_line == 1'b1, "R6", "line high while stalled", int'(tx_line), 1);
        check(tx_empty == 1'b0, "R9", "empty low with queued byte", int'(tx_empty), 0);
        cts_n = 1'b0;
        wait_idle();
        compare("R8");

        // R5/R6/R7: deassert during a frame
        s0 = starts;
        push(8'h11, 1'b0);
        push(8'h22, 1'b0);
        n = 0;
        while (starts == s0 && n < 2000) begin @(negedge clk); n++; end
        cts_n = 1'b1;
        n = 0;
        while (rx_q.size() < 1 && n < 2000) begin @(negedge clk); n++; end
        check(rx_q.size() == 1 && rx_q[0] == 8'h11, "R5", "frame finished intact",
              (rx_q.size() > 0) ? int'(rx_q[0]) : -1, 8'h11);
        repeat (400) @(negedge clk);
        check(starts == s0 + 1, "R6", "starts during stall", starts, s0 + 1);
        check(tx_line == 1'b1, "R6", "line high during stall", int'(tx_line), 1);
        cts_n = 1'b0;
        wait_idle();
        check(rx_q.size() == 2 && rx_q[1] == 8'h22, "R7", "next byte after resume",
              (rx_q.size() > 1) ? int'(rx_q[1]) : -1, 8'h22);
        rx_q.delete();

        // R3/R4: fill, overflow, drain
        cts_n = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 16; i++) push(8'(i*7 + 3), 1'b1);
        check(tx_overflow == 1'b0, "R4", "no overflow at 16", int'(tx_overflow), 0);
        push(8'hEE, 1'b0);
        check(tx_overflow == 1'b1, "R4", "overflow on 17th write", int'(tx_overflow), 1);
        cts_n = 1'b0;
        wait_idle();
        compare("R3");
        check(tx_overflow == 1'b1, "R4", "overflow sticky", int'(tx_overflow), 1);
        do_reset();

        // R3/R5/R7: random bursts with random flow control
        for (int b = 0; b < 6; b++) begin
            P = 1 + int'($urandom % 3);
            n = 1 + int'($urandom % 10);
            for (int k = 0; k < n; k++) push(8'($urandom), 1'b1);
            while (!tx_empty) begin
                cts_n = ($urandom % 3 == 0);
                repeat (50 + int'($urandom % 300)) @(negedge clk);
            end
            cts_n = 1'b0;
            wait_idle();
            compare("R7");
        end

        finish_run();
    end
endmodule